// File: doc/BRIEF.md
# Half-Rate Banked Instruction Fetch Unit

This block is the front end of an instruction fetch path. Its controller runs at the full processor clock, and it delivers up to one instruction word per cycle. The words come from two storage banks. Each bank can start a read only once every two processor cycles. Even word addresses live in one bank and odd word addresses in the other. The banks take turns on the two phases of a half-rate enable. As a result, a purely sequential stream lands on a bank that is ready in every cycle.

The requester presents a word address with a valid strobe. It must hold that address until it samples the ready signal high. In the cycle after an acceptance, the unit returns the instruction together with its address and a valid flag.

A request that does not follow the previous one sequentially is treated as a redirect. The unit holds ready low for one cycle to capture the new target. It may then hold ready low for one more cycle until the target's bank reaches its phase. During those cycles the banks keep re-reading the held address, and the output valid flag stays low. Only the correct instruction therefore reaches the pipeline.

Top module: `halfrate_fetch`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after reset is released, instrValid is low and reqReady is high for reqAddr 0.
- R2: If reqValid and reqReady are both high at a rising edge, the request is accepted. In the following cycle, instrValid is high and instrAddr equals the accepted address. Each acceptance yields exactly one valid output cycle.
- R3: A request for the previously accepted address plus one (modulo 2^ADDR_W, so the top address is followed by 0) is accepted with no stall when it is presented in the cycle right after that acceptance. A back-to-back sequential stream therefore yields one valid instruction per cycle.
- R4: Bit 0 of the word address selects the bank: 0 selects the even bank and 1 the odd bank. The remaining bits index within that bank. The word stored at address a is the low 32 bits of a*0x9E3779B1 + 0x01234567, and instrData carries that word for instrAddr.
- R5: A non-sequential request in the cycle right after an acceptance, with the same bit 0 as the previously accepted address, sees reqReady low for exactly one cycle before it is accepted.
- R6: A non-sequential request in the cycle right after an acceptance, with bit 0 different from the previously accepted address, sees reqReady low for exactly two cycles before it is accepted.
- R7: A sequential request that follows g cycles with reqValid low after an acceptance is accepted with no stall when g is even, and after one stall cycle when g is odd.
- R8: instrValid is low in every cycle that does not directly follow an acceptance. This includes stall cycles and idle cycles.
- R9: Once a redirect target has been accepted, its sequential successor in the next cycle is accepted with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Fetch request strobe |
| reqAddr | input | ADDR_W | Requested word address, held until accepted |
| reqReady | output | 1 | High when the presented address is accepted this cycle |
| instrValid | output | 1 | Instruction output is valid |
| instrAddr | output | ADDR_W | Word address of the returned instruction |
| instrData | output | 32 | Returned instruction word |

## Verification
Long back-to-back sequential runs, including a run across the top address, show that the bank alternation keeps pace with the clock and never inserts a bubble. Redirects are issued to targets with the same parity and with the opposite parity relative to the last accepted address. This separates the one-cycle capture cost from the extra alignment cycle, and a sequential fetch after each target confirms the stream resumes at full rate. Idle gaps of odd and even length show the stall that phase misalignment alone causes, with no redirect involved. A pseudo-random mix of redirects and short runs, plus a reset in the middle of a stream, confirms that the delivered addresses and words match the requests with nothing duplicated or lost.

// File: rtl/halfrate_fetch_pkg.sv
package halfrate_fetch_pkg;

  parameter int INSTR_W   = 32;
  parameter int NUM_BANKS = 2;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankEn;  // bank b may launch a read at this edge
    logic                 accept;  // request taken at this edge
  } fetch_strobe_t;

  // Preloaded content: a multiplicative hash of the word address.
  function automatic logic [INSTR_W-1:0] romWord(input logic [31:0] wordAddr);
    logic [31:0] prod;
    prod = wordAddr * 32'h9E3779B1;
    return prod + 32'h01234567;
  endfunction

endpackage

// File: rtl/halfrate_fetch_bank.sv
module halfrate_fetch_bank
  import halfrate_fetch_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int BANK_ID = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [IDX_W-1:0]   idx,
  output logic [INSTR_W-1:0] q
);

  localparam logic BANK_BIT = 1'(BANK_ID);

  logic [IDX_W:0] wordAddr;
  assign wordAddr = {idx, BANK_BIT};

  // Synchronous read, launched only on this bank's half-rate phase.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= romWord(32'(wordAddr));
  end

endmodule

// File: rtl/halfrate_fetch_ctrl.sv
module halfrate_fetch_ctrl
  import halfrate_fetch_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output fetch_strobe_t     strb
);

  logic              phase;     // half-rate toggle
  logic              redirect;  // target captured, waiting for its phase
  logic [ADDR_W-1:0] expAddr;   // next sequential address
  logic              isSeq;
  logic              aligned;
  logic              accept;

  assign isSeq    = (reqAddr == expAddr);
  assign aligned  = (reqAddr[0] == phase);
  assign reqReady = aligned && (isSeq || redirect);
  assign accept   = reqValid && reqReady;

  assign strb.accept = accept;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankEn
    assign strb.bankEn[b] = (phase == 1'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      redirect <= 1'b0;
      expAddr  <= '0;
    end else begin
      phase <= ~phase;
      if (accept) begin
        redirect <= 1'b0;
        expAddr  <= reqAddr + 1'b1;
      end else if (reqValid && !isSeq) begin
        redirect <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/halfrate_fetch_dp.sv
module halfrate_fetch_dp
  import halfrate_fetch_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  fetch_strobe_t      strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               instrValid,
  output logic [ADDR_W-1:0]  instrAddr,
  output logic [INSTR_W-1:0] instrData
);

  localparam int IDX_W = ADDR_W - 1;

  logic [INSTR_W-1:0] bankQ [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    halfrate_fetch_bank #(
      .IDX_W  (IDX_W),
      .BANK_ID(b)
    ) u_bank (
      .clk(clk),
      .rst(rst),
      .en (strb.bankEn[b]),
      .idx(reqAddr[ADDR_W-1:1]),
      .q  (bankQ[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instrValid <= 1'b0;
      instrAddr  <= '0;
    end else begin
      instrValid <= strb.accept;
      if (strb.accept) instrAddr <= reqAddr;
    end
  end

  // The bank that served the request holds its word for two cycles.
  assign instrData = bankQ[instrAddr[0]];

endmodule

// File: rtl/halfrate_fetch.sv
module halfrate_fetch
  import halfrate_fetch_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               reqReady,
  output logic               instrValid,
  output logic [ADDR_W-1:0]  instrAddr,
  output logic [INSTR_W-1:0] instrData
);

  fetch_strobe_t strb;

  halfrate_fetch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqAddr (reqAddr),
    .reqReady(reqReady),
    .strb    (strb)
  );

  halfrate_fetch_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .instrValid(instrValid),
    .instrAddr (instrAddr),
    .instrData (instrData)
  );

endmodule

// File: rtl/halfrate_fetch_chk.sv
module halfrate_fetch_chk
  import halfrate_fetch_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               reqReady,
  input logic               instrValid,
  input logic [ADDR_W-1:0]  instrAddr,
  input logic [INSTR_W-1:0] instrData
);

  logic              live;
  logic              prevAccept;
  logic [ADDR_W-1:0] prevAddr;
  logic [ADDR_W-1:0] seqNext;

  assign seqNext = prevAddr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      live       <= 1'b0;
      prevAccept <= 1'b0;
      prevAddr   <= '0;
    end else begin
      live       <= 1'b1;
      prevAccept <= reqValid && reqReady;
      prevAddr   <= reqAddr;
    end
  end

  assert_accept_returns_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> (instrValid && instrAddr == prevAddr));

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !(reqValid && reqReady) |=> !instrValid);

  assert_word_matches_R4: assert property (@(posedge clk) disable iff (rst)
    instrValid |-> (instrData == romWord(32'(instrAddr))));

  assert_seq_no_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (live && prevAccept && reqValid && reqAddr == seqNext) |-> reqReady);

  assert_jump_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    (live && prevAccept && reqValid && reqAddr != seqNext) |-> !reqReady);

endmodule

bind halfrate_fetch halfrate_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqReady  (reqReady),
  .instrValid(instrValid),
  .instrAddr (instrAddr),
  .instrData (instrData)
);

// File: tb/halfrate_fetch_tb.sv
module halfrate_fetch_tb;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          reqValid;
  logic [AW-1:0] reqAddr;
  logic          reqReady;
  logic          instrValid;
  logic [AW-1:0] instrAddr;
  logic [31:0]   instrData;

  int checks   = 0;
  int failures = 0;
  logic done = 1'b0;

  logic          pendValid = 1'b0;
  logic [AW-1:0] pendAddr  = '0;
  logic [AW-1:0] lastAddr  = '0;
  logic [31:0]   lfsr      = 32'hACE1_2357;

  always #10 clk = ~clk;

  halfrate_fetch #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .instrValid(instrValid), .instrAddr(instrAddr),
    .instrData(instrData)
  );

  function automatic logic [31:0] refWord(input logic [AW-1:0] a);
    logic [31:0] m;
    m = 32'(a) * 32'd2654435761;
    return m + 32'd19088743;
  endfunction

  task automatic check(input logic ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One cycle: check the outputs of the previous edge, then drive the next request.
  task automatic step(input logic v, input logic [AW-1:0] a, output logic acc);
    @(negedge clk);
    if (pendValid) begin
      check(instrValid === 1'b1, "R2 valid after accept", instrValid, 1);
      check(instrAddr === pendAddr, "R2 returned address", instrAddr, pendAddr);
      check(instrData === refWord(pendAddr), "R4 instruction word",
            instrData, refWord(pendAddr));
    end else begin
      check(instrValid === 1'b0, "R8 no valid without accept", instrValid, 0);
    end
    reqValid = v;
    reqAddr  = a;
    #1;
    acc       = v && reqReady;
    pendValid = acc;
    pendAddr  = a;
  endtask

  task automatic fetch(input logic [AW-1:0] a, output int stalls);
    logic acc;
    acc    = 1'b0;
    stalls = 0;
    for (int i = 0; i < 6 && !acc; i++) begin
      step(1'b1, a, acc);
      if (!acc) stalls++;
    end
    lastAddr = a;
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int i = 0; i < n; i++) step(1'b0, reqAddr, acc);
  endtask

  task automatic doReset();
    rst      = 1'b1;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    check(instrValid === 1'b0, "R1 valid low in reset", instrValid, 0);
    rst      = 1'b0;
    reqAddr  = '0;
    reqValid = 1'b1;
    #1;
    check(instrValid === 1'b0, "R1 valid low after reset", instrValid, 0);
    check(reqReady === 1'b1, "R1 address 0 ready at start", reqReady, 1);
    pendValid = reqReady;
    pendAddr  = '0;
    lastAddr  = '0;
  endtask

  task automatic testSeqRun(input int n);
    int s;
    for (int i = 0; i < n; i++) begin
      fetch(lastAddr + 1'b1, s);
      check(s == 0, "R3 sequential no stall", s, 0);
    end
  endtask

  // Redirect right after an accept; stall count follows the parity rule.
  task automatic testJump(input logic [AW-1:0] t);
    int s;
    int exp;
    exp = (t[0] == lastAddr[0]) ? 1 : 2;
    fetch(t, s);
    if (exp == 1) check(s == 1, "R5 same-parity redirect stall", s, 1);
    else          check(s == 2, "R6 opposite-parity redirect stall", s, 2);
    fetch(t + 1'b1, s);
    check(s == 0, "R9 successor of target no stall", s, 0);
  endtask

  task automatic testGap(input int g);
    int s;
    idle(g);
    fetch(lastAddr + 1'b1, s);
    check(s == g % 2, "R7 stall after idle gap", s, g % 2);
  endtask

  task automatic testWrap();
    int s;
    testJump(8'hFD);
    fetch(8'hFF, s);
    check(s == 0, "R3 sequential to top address", s, 0);
    fetch(8'h00, s);
    check(s == 0, "R3 wrap to address 0 no stall", s, 0);
  endtask

  task automatic testMixed(input int n);
    logic [AW-1:0] t;
    for (int i = 0; i < n; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      t = lfsr[AW-1:0];
      if (t == lastAddr + 1'b1) t = t + 2'd2;
      testJump(t);
      testSeqRun(int'(lfsr[9:8]));
    end
  endtask

  initial begin
    reqValid = 1'b0;
    reqAddr  = '0;
    rst      = 1'b1;
    doReset();
    testSeqRun(16);
    testJump(lastAddr + 8'd6);
    testJump(lastAddr + 8'd9);
    testGap(1);
    testGap(2);
    testGap(3);
    testWrap();
    testMixed(40);
    testSeqRun(5);
    doReset();
    testSeqRun(4);
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule